// File: doc/BRIEF.md
# Line Transceiver Enable and Clock Routing Controller

This block holds the per-channel control bits that decide when the line transceivers of a four-channel serial interface are switched on. Software writes the bits through a byte-wide local bus. For each channel, three combinational outputs gate the data receiver, the data driver and the transmit-clock driver. Each gate is either forced on or follows the channel's RTS signal. The receiver follows RTS in the opposite sense to the two drivers, so a two-wire half-duplex link stops hearing its own transmission while it is sending.

A second register sets two routing switches per channel. One connects the serial controller's transmit-clock pin to the incoming send-timing receiver (ST). The other connects the same pin to the outgoing terminal-timing driver (TT). Both switch bits are active low. Closing both switches at once passes an external clock straight through to the TT output.

The register storage is the only state in the block. Every output is a pure function of the stored bits and of the RTS inputs, so a changed setting appears at the pins in the cycle right after the write edge.

Top module: `lnk_line_ctrl`

## Requirements
- R1: The enable bits sit in two bytes. Byte offset 0 holds channel 0 in bits 3:0 and channel 1 in bits 7:4. Byte offset 1 holds channel 2 in bits 3:0 and channel 3 in bits 7:4. A write stores the data at the clock edge where `bus_wr` is high.
- R2: Nibble bit 0 controls the receiver. When it is 1, `rx_en_o` for that channel is 1. When it is 0, `rx_en_o` equals the inverse of that channel's `rts_i`.
- R3: Nibble bit 1 controls the data driver. When it is 1, `tx_en_o` is 1. When it is 0, `tx_en_o` equals `rts_i`.
- R4: Nibble bit 2 controls the clock driver. When it is 1, `tt_en_o` is 1. When it is 0, `tt_en_o` equals `rts_i`.
- R5: Nibble bit 3 (byte bits 3 and 7) has no function. It is not stored, it reads back as 0, and it has no effect on any output.
- R6: Byte offset 2 holds the routing bits. Channel c uses bit 2c for ST and bit 2c+1 for TT. `st_link_o[c]` is 1 exactly when bit 2c is 0, and `tt_link_o[c]` is 1 exactly when bit 2c+1 is 0.
- R7: After reset the following hold:
  - Offsets 0 and 1 read 0x77 and offset 2 reads 0x55.
  - Every `rx_en_o`, `tx_en_o` and `tt_en_o` is 1 regardless of RTS.
  - Every `st_link_o` is 0 and every `tt_link_o` is 1.
- R8: Both routing switches of a channel may be closed at once. Offset 2 value 0x00 gives all `st_link_o` and all `tt_link_o` equal to 1.
- R9: `bus_rdata` combinationally shows the stored bits at `bus_addr`. Offset 3 reads 0, and a write to offset 3 changes no stored bit and no output.
- R10: Outputs reflect new register contents in the cycle that follows the write edge. They follow `rts_i` changes with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 2 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| rts_i | input | 4 | Per-channel RTS from the serial controller |
| tclk_oe_i | input | 4 | Per-channel transmit-clock pin output enable from the serial controller |
| rx_en_o | output | 4 | Data receiver enable |
| tx_en_o | output | 4 | Data driver enable |
| tt_en_o | output | 4 | Transmit-clock driver enable |
| st_link_o | output | 4 | ST receiver switch closed |
| tt_link_o | output | 4 | TT driver switch closed |

## Verification
The contention assertion assumes one thing about the serial controller: it never drives its transmit-clock pin (`tclk_oe_i` high) while the ST receiver is switched onto that pin. The stimulus respects this in two ways. It raises `tclk_oe_i` only while the routing register holds its reset value, with every ST switch open. It holds `tclk_oe_i` low for the whole routing sweep. The write-capture assertions assume that `bus_addr` and `bus_wdata` are stable around the write edge. The bench meets this by changing bus inputs only on falling edges.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

    // Per-channel enable controls, nibble bits 2..0
    typedef struct packed {
        logic tt_hold;   // bit 2: clock driver forced on
        logic tx_hold;   // bit 1: data driver forced on
        logic rx_hold;   // bit 0: receiver forced on
    } lane_cfg_t;

    // Per-channel routing controls, active low
    typedef struct packed {
        logic tt_open;   // bit 1: TT switch open
        logic st_open;   // bit 0: ST switch open
    } route_cfg_t;

    localparam int LANE_BITS   = $bits(lane_cfg_t);
    localparam int ROUTE_BITS  = $bits(route_cfg_t);
    localparam int NIBBLE_W    = 4;
    localparam int LANES_PER_B = 8 / NIBBLE_W;
    localparam int ROUTE_PER_B = 8 / ROUTE_BITS;

    localparam lane_cfg_t  LANE_RST  = '{tt_hold: 1'b1, tx_hold: 1'b1, rx_hold: 1'b1};
    localparam route_cfg_t ROUTE_RST = '{tt_open: 1'b0, st_open: 1'b1};

endpackage

// File: rtl/lnk_regfile.sv
module lnk_regfile
    import lnk_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [7:0]                bus_wdata,
    output logic [7:0]                bus_rdata,
    output lane_cfg_t  [NUM_CH-1:0]   lane_cfg_o,
    output route_cfg_t [NUM_CH-1:0]   route_cfg_o
);

    localparam int EN_BYTES = NUM_CH / LANES_PER_B;
    localparam int CK_BYTES = NUM_CH / ROUTE_PER_B;
    localparam int MAP_BYTES = EN_BYTES + CK_BYTES;

    lane_cfg_t  [NUM_CH-1:0] lane_q;
    route_cfg_t [NUM_CH-1:0] route_q;

    // Storage: only functional bits are kept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q  <= {NUM_CH{LANE_RST}};
            route_q <= {NUM_CH{ROUTE_RST}};
        end else if (bus_wr) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (bus_addr == ADDR_W'(c / LANES_PER_B))
                    lane_q[c] <= bus_wdata[(c % LANES_PER_B) * NIBBLE_W +: LANE_BITS];
                if (bus_addr == ADDR_W'(EN_BYTES + c / ROUTE_PER_B))
                    route_q[c] <= bus_wdata[(c % ROUTE_PER_B) * ROUTE_BITS +: ROUTE_BITS];
            end
        end
    end

    // Read mux: unmapped bits and offsets give zero
    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (bus_addr == ADDR_W'(c / LANES_PER_B))
                bus_rdata[(c % LANES_PER_B) * NIBBLE_W +: LANE_BITS] = lane_q[c];
            if (bus_addr == ADDR_W'(EN_BYTES + c / ROUTE_PER_B))
                bus_rdata[(c % ROUTE_PER_B) * ROUTE_BITS +: ROUTE_BITS] = route_q[c];
        end
    end

    assign lane_cfg_o  = lane_q;
    assign route_cfg_o = route_q;

    // Write capture and spare-bit checks per channel
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        localparam int LO   = (c % LANES_PER_B) * NIBBLE_W;
        localparam int RLO  = (c % ROUTE_PER_B) * ROUTE_BITS;
        localparam logic [ADDR_W-1:0] LA = ADDR_W'(c / LANES_PER_B);
        localparam logic [ADDR_W-1:0] RA = ADDR_W'(EN_BYTES + c / ROUTE_PER_B);

        p_lane_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == LA) |=> (lane_q[c] == $past(bus_wdata[LO +: LANE_BITS])));

        p_spare_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == LA && bus_wdata[LO + NIBBLE_W - 1])
            |=> (lane_q[c] == $past(bus_wdata[LO +: LANE_BITS])));

        p_route_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == RA) |=> (route_q[c] == $past(bus_wdata[RLO +: ROUTE_BITS])));
    end

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr || bus_addr >= ADDR_W'(MAP_BYTES)) |=> ($stable(lane_q) && $stable(route_q)));

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= ADDR_W'(MAP_BYTES)) |-> (bus_rdata == 8'h00));

endmodule

// File: rtl/lnk_chan_gate.sv
module lnk_chan_gate
    import lnk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rts,
    input  logic        tclk_oe,
    input  lane_cfg_t   lane,
    input  route_cfg_t  route,
    output logic        rx_en,
    output logic        tx_en,
    output logic        tt_en,
    output logic        st_link,
    output logic        tt_link
);

    // Receiver listens while not sending; drivers work while sending
    always_comb begin
        rx_en   = lane.rx_hold | ~rts;
        tx_en   = lane.tx_hold |  rts;
        tt_en   = lane.tt_hold |  rts;
        st_link = ~route.st_open;
        tt_link = ~route.tt_open;
    end

    p_rx_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rts |-> rx_en);
    p_rx_echo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rts && !lane.rx_hold) |-> !rx_en);
    p_tx_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rts && !lane.tx_hold) |-> !tx_en);
    p_tt_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rts && !lane.tt_hold) |-> !tt_en);
    // Controller must not drive its clock pin onto the ST receiver path
    p_st_vs_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_link |-> !tclk_oe);

endmodule

// File: rtl/lnk_line_ctrl.sv
module lnk_line_ctrl
    import lnk_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [NUM_CH-1:0] rts_i,
    input  logic [NUM_CH-1:0] tclk_oe_i,
    output logic [NUM_CH-1:0] rx_en_o,
    output logic [NUM_CH-1:0] tx_en_o,
    output logic [NUM_CH-1:0] tt_en_o,
    output logic [NUM_CH-1:0] st_link_o,
    output logic [NUM_CH-1:0] tt_link_o
);

    lane_cfg_t  [NUM_CH-1:0] lane_cfg;
    route_cfg_t [NUM_CH-1:0] route_cfg;

    lnk_regfile #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .lane_cfg_o  (lane_cfg),
        .route_cfg_o (route_cfg)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        lnk_chan_gate u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .rts     (rts_i[c]),
            .tclk_oe (tclk_oe_i[c]),
            .lane    (lane_cfg[c]),
            .route   (route_cfg[c]),
            .rx_en   (rx_en_o[c]),
            .tx_en   (tx_en_o[c]),
            .tt_en   (tt_en_o[c]),
            .st_link (st_link_o[c]),
            .tt_link (tt_link_o[c])
        );
    end

    p_reset_defaults_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (st_link_o == '0 && tt_link_o == '1 && rx_en_o == '1
                          && tx_en_o == '1 && tt_en_o == '1));

endmodule

// File: tb/tb_lnk_line_ctrl.sv
module tb_lnk_line_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] rts_i = '0;
    logic [3:0] tclk_oe_i = '0;
    logic [3:0] rx_en_o, tx_en_o, tt_en_o, st_link_o, tt_link_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [4];   // expected register image, offset 3 always 0

    always #4 clk = ~clk;    // 125 MHz

    lnk_line_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rts_i(rts_i),
        .tclk_oe_i(tclk_oe_i), .rx_en_o(rx_en_o), .tx_en_o(tx_en_o),
        .tt_en_o(tt_en_o), .st_link_o(st_link_o), .tt_link_o(tt_link_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 2'd0 || a == 2'd1) model[a] = d & 8'h77;
        else if (a == 2'd2) model[a] = d;
    endtask

    function automatic logic [2:0] nib(input int c);
        return model[c / 2][(c % 2) * 4 +: 3];
    endfunction

    // Enable outputs vs. model for the present RTS pattern
    task automatic check_enables(input string tg);
        logic [3:0] erx, etx, ett;
        for (int c = 0; c < 4; c++) begin
            erx[c] = nib(c)[0] | ~rts_i[c];
            etx[c] = nib(c)[1] |  rts_i[c];
            ett[c] = nib(c)[2] |  rts_i[c];
        end
        chk({tg, " R2 rx_en"}, {4'h0, rx_en_o}, {4'h0, erx});
        chk({tg, " R3 tx_en"}, {4'h0, tx_en_o}, {4'h0, etx});
        chk({tg, " R4 tt_en"}, {4'h0, tt_en_o}, {4'h0, ett});
    endtask

    task automatic check_links(input string tg);
        logic [3:0] est, ett;
        for (int c = 0; c < 4; c++) begin
            est[c] = ~model[2][2 * c];
            ett[c] = ~model[2][2 * c + 1];
        end
        chk({tg, " R6 st_link"}, {4'h0, st_link_o}, {4'h0, est});
        chk({tg, " R6 tt_link"}, {4'h0, tt_link_o}, {4'h0, ett});
    endtask

    task automatic check_reset_state();
        model[0] = 8'h77; model[1] = 8'h77; model[2] = 8'h55; model[3] = 8'h00;
        for (int a = 0; a < 4; a++) begin
            bus_addr = 2'(a);
            #1;
            chk("R7 reset readback", bus_rdata, model[a]);
        end
        for (int p = 0; p < 16; p += 5) begin
            rts_i = 4'(p);
            #1;
            chk("R7 reset rx_en", {4'h0, rx_en_o}, 8'h0F);
            chk("R7 reset tx_en", {4'h0, tx_en_o}, 8'h0F);
            chk("R7 reset tt_en", {4'h0, tt_en_o}, 8'h0F);
        end
        chk("R7 reset st_link", {4'h0, st_link_o}, 8'h00);
        chk("R7 reset tt_link", {4'h0, tt_link_o}, 8'h0F);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        tclk_oe_i = 4'hF;   // safe: every ST switch is open at reset
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state();
        tclk_oe_i = 4'h0;

        // R1..R5, R10: exhaustive byte sweep of both enable offsets
        for (int a = 0; a < 2; a++) begin
            for (int v = 0; v < 256; v++) begin
                bus_write(2'(a), 8'(v));
                bus_addr = 2'(a);
                #1;
                chk("R1 R5 enable readback", bus_rdata, model[a]);
                foreach (model[k]) begin end
                for (int p = 0; p < 16; p += 5) begin
                    rts_i = 4'(p);
                    #1;
                    check_enables("R10");
                end
            end
        end

        // R6, R8: exhaustive routing sweep, tclk_oe held low
        for (int v = 0; v < 256; v++) begin
            bus_write(2'd2, 8'(v));
            bus_addr = 2'd2;
            #1;
            chk("R6 route readback", bus_rdata, model[2]);
            check_links("R6");
        end
        bus_write(2'd2, 8'h00);
        #1;
        chk("R8 both st_link", {4'h0, st_link_o}, 8'h0F);
        chk("R8 both tt_link", {4'h0, tt_link_o}, 8'h0F);

        // R9: offset 3 reads zero and absorbs writes
        bus_write(2'd0, 8'h52);
        bus_write(2'd1, 8'h25);
        bus_write(2'd3, 8'hFF);
        for (int a = 0; a < 4; a++) begin
            bus_addr = 2'(a);
            #1;
            chk("R9 image after offset-3 write", bus_rdata, model[a]);
        end
        rts_i = 4'h6;
        #1;
        check_enables("R9");
        check_links("R9");

        // R7: reset applied mid-run restores defaults
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        tclk_oe_i = 4'hF;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule